// File: doc/BRIEF.md
# Pulse-Output Timer with One-Shot Mode

A 32-bit timer that produces a pulse-width-modulated output. Software supplies a period and a width. Once the timer is started, it counts from 1 up to the period and then starts again at 1. The output is high while the count lies between 1 and the width, and low for the rest of the period. The count advances on every system clock cycle, or on each rising edge of an external input pin after that pin is synchronized. A configuration bit picks the source.

A mode bit selects between two behaviours. In continuous mode the waveform repeats, and the interrupt status is set each time a period ends. In one-shot mode the timer emits a single pulse. When the width runs out, it raises the interrupt status and turns itself off. The timer is started and stopped by separate strobes. The interrupt status is sticky and cleared by a write-one strobe. A start request with an unusable period and width combination sets an error flag and does nothing else. A separate control drops the output enable of the pin so that the pin can float.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0, and the output, interrupt, error and running flags are all 0.
- R2: A start strobe while idle, with period 0, width 0, or width greater than or equal to period, sets the error flag and leaves the timer stopped. A valid start clears the error flag.
- R3: After a valid start the count reads 0 for one tick and then runs 1, 2, …, period, 1, 2, …. The output is 1 exactly while the timer runs and the count is between 1 and the width, inclusive.
- R4: In continuous mode (mode bit = 1), the interrupt status becomes 1 on the tick that takes the count from the period value back to 1, and the timer keeps running.
- R5: In one-shot mode (mode bit = 0), on the tick after the count reaches the width, the timer stops itself, the interrupt status becomes 1, and the count holds at the width value.
- R6: The interrupt status stays 1 until a clear strobe. It is 0 in the cycle after the clear, unless a new interrupt event occurs in the same cycle.
- R7: A stop strobe stops the timer on the next edge, drives the output low and freezes the count. A stop has priority over a start and over a tick in the same cycle.
- R8: With the clock-select bit = 1, the count advances once per rising edge of the external input after two synchronizing flops, and does not advance on system clock cycles without such an edge.
- R9: The output-enable port is 0 while the output-disable bit is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_in | input | 1 | External count source, asynchronous |
| cfg_cont | input | 1 | 1 continuous PWM, 0 one-shot; latched at start |
| cfg_ext_sel | input | 1 | 1 count external edges, 0 count system clock; latched at start |
| cfg_out_dis | input | 1 | 1 releases the output pin |
| period_i | input | CW | Period in ticks; latched at start |
| width_i | input | CW | High time in ticks; latched at start |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| irq_clr_i | input | 1 | Write-one clear of interrupt status |
| pwm_o | output | 1 | Waveform output |
| pwm_oe_o | output | 1 | Output enable for the pin |
| irq_o | output | 1 | Sticky interrupt status |
| err_o | output | 1 | Rejected configuration flag |
| running_o | output | 1 | Timer running |
| count_o | output | CW | Live count value |

## Verification
On every cycle, the assertions check the following: the output is high only while the timer runs; a running count never goes past the latched period; an idle timer holds its count; a stop always ends the run; the interrupt status stays set until it is cleared; and an error never coincides with a started timer. The exact tick sequence, where the interrupt lands in each mode, the one-shot self-stop point, the rejection of every bad period and width pair, and the counting of external edges can only be shown by the bench's sweeps. The bench sweeps small periods and widths and compares each against counts it computes itself.

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_clk_in,
  input  logic          cfg_cont,
  input  logic          cfg_ext_sel,
  input  logic          cfg_out_dis,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] width_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          irq_clr_i,
  output logic          pwm_o,
  output logic          pwm_oe_o,
  output logic          irq_o,
  output logic          err_o,
  output logic          running_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] per_q, wid_q, cnt_q;
  logic          cont_q, ext_q, run_q, irq_q, err_q;
  logic [2:0]    sync_q;

  wire ext_edge  = sync_q[1] & ~sync_q[2];
  wire tick      = run_q & ~stop_i & (ext_q ? ext_edge : 1'b1);
  wire cfg_bad   = (period_i == '0) || (width_i == '0) || (width_i >= period_i);
  wire wrap_evt  = tick & cont_q & (cnt_q == per_q);
  wire shot_evt  = tick & ~cont_q & (cnt_q == wid_q);
  wire do_start  = start_i & ~run_q & ~stop_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ext_clk_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      wid_q  <= '0;
      cnt_q  <= '0;
      cont_q <= 1'b0;
      ext_q  <= 1'b0;
      run_q  <= 1'b0;
      err_q  <= 1'b0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (do_start) begin
      if (cfg_bad) begin
        err_q <= 1'b1;
      end else begin
        err_q  <= 1'b0;
        run_q  <= 1'b1;
        cnt_q  <= '0;
        per_q  <= period_i;
        wid_q  <= width_i;
        cont_q <= cfg_cont;
        ext_q  <= cfg_ext_sel;
      end
    end else if (tick) begin
      if (shot_evt)      run_q <= 1'b0;
      else if (wrap_evt) cnt_q <= ONE;
      else               cnt_q <= cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wrap_evt | shot_evt | (irq_q & ~irq_clr_i);

  assign pwm_o     = run_q && (cnt_q != '0) && (cnt_q <= wid_q);
  assign pwm_oe_o  = ~cfg_out_dis;
  assign irq_o     = irq_q;
  assign err_o     = err_q;
  assign running_o = run_q;
  assign count_o   = cnt_q;

  AST_PWM_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_o |-> running_o); // R3
  AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    running_o |-> count_o <= per_q); // R3
  AST_ERR_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !running_o); // R2
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i |=> irq_o); // R6
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !running_o && $stable(count_o)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o && !start_i |=> $stable(count_o)); // R5
endmodule

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb_top;
  localparam int CW = 32;
  logic clk = 0, rst_n = 0, ext_clk_in = 0, cfg_cont = 0, cfg_ext_sel = 0, cfg_out_dis = 0;
  logic [CW-1:0] period_i = '0, width_i = '0;
  logic start_i = 0, stop_i = 0, irq_clr_i = 0;
  logic pwm_o, pwm_oe_o, irq_o, err_o, running_o;
  logic [CW-1:0] count_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwm_timer #(.CW(CW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(); @(posedge clk); #1; endtask

  task automatic halt_clear();
    stop_i = 1; irq_clr_i = 1; cyc(); stop_i = 0; irq_clr_i = 0; cyc();
  endtask

  task automatic start(input int p, input int w, input bit cont, input bit ext);
    period_i = p; width_i = w; cfg_cont = cont; cfg_ext_sel = ext;
    start_i = 1; cyc(); start_i = 0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk(count_o == 0 && !pwm_o && !irq_o && !err_o && !running_o, "R1", count_o, 0);
    cyc(); cyc(); rst_n = 1; cyc();
    chk(count_o == 0 && !pwm_o && !irq_o && !err_o && !running_o, "R1", {pwm_o, irq_o, err_o, running_o}, 0);

    for (int mode = 0; mode < 2; mode++)
      for (int p = 0; p <= 6; p++)
        for (int w = 0; w <= 7; w++) begin
          halt_clear();
          start(p, w, mode[0], 1'b0);
          if (p == 0 || w == 0 || w >= p) begin
            chk(err_o && !running_o, "R2", {err_o, running_o}, 2);
          end else begin
            chk(!err_o, "R2", err_o, 0);
            for (int k = 0; k <= 2*p + 3; k++) begin
              int ec; bit er, ei, ep;
              if (mode == 1) begin
                ec = (k == 0) ? 0 : ((k - 1) % p) + 1;
                er = 1; ei = (k >= p + 1);
              end else begin
                ec = (k <= w) ? k : w;
                er = (k <= w); ei = (k >= w + 1);
              end
              ep = er && ec >= 1 && ec <= w;
              chk(count_o == ec, "R3", count_o, ec);
              chk(pwm_o == ep && running_o == er, "R3", {pwm_o, running_o}, {ep, er});
              chk(irq_o == ei, mode == 1 ? "R4" : "R5", irq_o, ei);
              cyc();
            end
          end
        end

    halt_clear();
    start(4, 2, 1'b0, 1'b0);
    repeat (8) cyc();
    chk(irq_o && !running_o && count_o == 2, "R5", count_o, 2);
    repeat (3) cyc();
    chk(irq_o, "R6", irq_o, 1);
    irq_clr_i = 1; cyc(); irq_clr_i = 0;
    chk(!irq_o, "R6", irq_o, 0);
    repeat (3) cyc();
    chk(!irq_o && count_o == 2, "R6", irq_o, 0);

    halt_clear();
    start(5, 2, 1'b1, 1'b0);
    cyc(); cyc();
    chk(count_o == 2 && pwm_o, "R3", count_o, 2);
    stop_i = 1; cyc(); stop_i = 0;
    chk(!running_o && !pwm_o && count_o == 2, "R7", count_o, 2);
    repeat (4) cyc();
    chk(!running_o && !pwm_o && count_o == 2, "R7", count_o, 2);
    stop_i = 1; start_i = 1; cyc(); stop_i = 0; start_i = 0;
    chk(!running_o && count_o == 2, "R7", running_o, 0);

    halt_clear();
    start(3, 2, 1'b1, 1'b1);
    repeat (6) cyc();
    chk(count_o == 0 && running_o, "R8", count_o, 0);
    for (int n = 1; n <= 10; n++) begin
      int ec;
      ext_clk_in = 1; repeat (4) cyc();
      ec = ((n - 1) % 3) + 1;
      chk(count_o == ec, "R8", count_o, ec);
      chk(pwm_o == (ec <= 2), "R8", pwm_o, ec <= 2);
      chk(irq_o == (n >= 4), "R8", irq_o, n >= 4);
      ext_clk_in = 0; repeat (4) cyc();
      chk(count_o == ec, "R8", count_o, ec);
    end

    cfg_out_dis = 1; #1;
    chk(!pwm_oe_o, "R9", pwm_oe_o, 0);
    cfg_out_dis = 0; #1;
    chk(pwm_oe_o, "R9", pwm_oe_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule